// File: doc/BRIEF.md
# Prescaled Auto-Reload Up-Counting Timer

This block is a timer peripheral on a simple 32-bit register bus. A programmable divider slows the input clock. Each divided tick advances an up-counter. When the counter reaches a programmed reload limit, it returns to zero on that same tick. If interrupts are enabled, the wrap sets a sticky update flag and drives a one-cycle interrupt pulse. Software starts and stops counting, loads the counter directly, forces a restart, and clears the flag by writing zeros into the status word. A bank of plain storage words sits beside the timer registers. These words hold configuration for features the block does not implement, and they have no effect on timing.

Counting is governed by a two-state run machine. In state `ST_HALTED` the counter and the divider hold still. In state `ST_COUNTING` the divider runs and the counter advances on its ticks. The transition START (`ST_HALTED` to `ST_COUNTING`) happens when software writes the control word with bit 0 set. The transition STOP (`ST_COUNTING` to `ST_HALTED`) happens when software writes the control word with bit 0 clear. Any other cycle keeps the current state.

Register map (byte offsets, word aligned):
- 0x00 control
- 0x04 interrupt enable
- 0x08 status
- 0x0C event
- 0x10 count
- 0x14 divider
- 0x18 reload
- 0x20 + 4·i for the storage words

Top module: `reload_timer`

## Requirements
- R1: While counting, the counter advances once every (divider + 1) clock cycles. The divider restarts from zero when counting starts, so the first advance comes (divider + 1) cycles after the START write.
- R2: Counting happens only in `ST_COUNTING`. Control bit 0 written as 1 is START and written as 0 is STOP. A halted counter holds its value, and no update event occurs unless the block is counting and interrupt-enable bit 0 is set.
- R3: A tick that finds the counter equal to a non-zero reload value returns the counter to 0 on that edge. When interrupts are enabled, the same edge sets status bit 0 and raises `upd_irq` for exactly one cycle.
- R4: A status write stores the old value ANDed with the written data: writing 1 to bit 0 keeps the flag and writing 0 clears it. A flag set by hardware in the same cycle wins.
- R5: An event-word write with bit 0 set loads the counter with 0 and restarts the divider, so the next advance comes (divider + 1) cycles later. Writing it with bit 0 clear does nothing, and the event word reads as 0.
- R6: Writing the divider leaves the current count unchanged.
- R7: The count word can be written directly, keeping its low CNT_W bits, and counting continues from the written value.
- R8: With a reload value of 0, no update event is ever produced, and the counter free-runs, wrapping from 2^CNT_W−1 to 0.
- R9: With interrupt-enable bit 0 clear, the counter still wraps at the reload value, but neither the flag nor the pulse appears.
- R10: After reset every register reads 0 and `upd_irq` is low. Offsets are as in the register map above.
- R11: Storage words read back all 32 written bits. Control bits 31:1 and all 32 interrupt-enable bits are stored and read back. Divider and reload keep their low PSC_W and CNT_W bits.
- R12: Reads of undefined or non-word-aligned addresses return 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from address |
| upd_irq | output | 1 | One-cycle update interrupt pulse |

## Verification
The bench builds the block with CNT_W = 8, PSC_W = 8 and N_STORE = 4. The narrow counter puts the free-running wrap at reload 0 within a few hundred cycles. The narrow divider and counter make truncation of wide writes visible on read-back. With four storage words, the address just past the bank is an undefined offset that the bench can probe. Divider values of 0 to 3 make the exact tick spacing, the restart after a forced event, and the wrap-cycle pulse observable cycle by cycle.

// File: rtl/rt_pkg.sv
package rt_pkg;
    localparam int WORD_CTRL   = 0;
    localparam int WORD_IEN    = 1;
    localparam int WORD_STAT   = 2;
    localparam int WORD_EVT    = 3;
    localparam int WORD_COUNT  = 4;
    localparam int WORD_PDIV   = 5;
    localparam int WORD_RELOAD = 6;
    localparam int WORD_STORE0 = 8;

    typedef enum logic {
        ST_HALTED   = 1'b0,
        ST_COUNTING = 1'b1
    } run_state_e;
endpackage

// File: rtl/rt_prescaler.sv
module rt_prescaler #(
    parameter int PSC_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             clr,
    input  logic [PSC_W-1:0] pdiv,
    output logic             tick
);
    logic [PSC_W-1:0] pcnt_q;

    // Compare with >= so a divider lowered below the running phase still ticks.
    assign tick = run && !clr && (pcnt_q >= pdiv);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pcnt_q <= '0;
        end else if (clr || !run || tick) begin
            pcnt_q <= '0;
        end else begin
            pcnt_q <= pcnt_q + 1'b1;
        end
    end

    // R1: with a non-zero divider two ticks never fall on adjacent cycles
    assert_tick_gap_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && pdiv != '0) |=> (!tick || pdiv == '0));
endmodule

// File: rtl/rt_count_fsm.sv
module rt_count_fsm
    import rt_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctrl_wr,
    input  logic             ctrl_run,
    input  logic             cnt_wr,
    input  logic [CNT_W-1:0] cnt_wdata,
    input  logic             ug,
    input  logic             tick,
    input  logic [CNT_W-1:0] reload,
    input  logic             upd_ien,
    input  logic             stat_wr,
    input  logic             stat_keep,
    output logic             run,
    output logic [CNT_W-1:0] cnt,
    output logic             stat,
    output logic             irq
);
    run_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_d;
    logic             stat_d;
    logic             wrap;
    logic             upd_evt;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_HALTED;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HALTED:   if (ctrl_wr && ctrl_run)  state_d = ST_COUNTING; // START
            ST_COUNTING: if (ctrl_wr && !ctrl_run) state_d = ST_HALTED;   // STOP
            default:     state_d = ST_HALTED;
        endcase
    end

    assign run     = (state_q == ST_COUNTING);
    assign wrap    = tick && !ug && !cnt_wr && (reload != '0) && (cnt == reload);
    assign upd_evt = wrap && upd_ien;

    always_comb begin
        if (ug)          cnt_d = '0;
        else if (cnt_wr) cnt_d = cnt_wdata;
        else if (wrap)   cnt_d = '0;
        else if (tick)   cnt_d = cnt + 1'b1;
        else             cnt_d = cnt;
        stat_d = (stat_wr ? (stat & stat_keep) : stat) | upd_evt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt  <= '0;
            stat <= 1'b0;
            irq  <= 1'b0;
        end else begin
            cnt  <= cnt_d;
            stat <= stat_d;
            irq  <= upd_evt;
        end
    end

    // R2: a pulse needs the block counting and enabled on the previous cycle
    assert_evt_needs_run_R2: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ($past(run) && $past(upd_ien)));
    // R3: the pulse comes with the flag and lasts one cycle
    assert_flag_with_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> stat);
    assert_single_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);
    // R5: a forced event leaves the counter at zero
    assert_ug_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ug |=> (cnt == '0));
    // R8: no pulse follows a cycle with zero reload
    assert_no_evt_zero_reload_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (reload == '0) |=> !irq);
    // R2: a halted counter holds unless software writes it
    assert_halt_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !cnt_wr && !ug) |=> $stable(cnt));
endmodule

// File: rtl/rt_store.sv
module rt_store #(
    parameter int N_STORE = 12,
    parameter int WIDX_W  = 6,
    parameter int BASE    = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [WIDX_W-1:0] idx,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    output logic              hit
);
    logic [31:0] words [N_STORE];

    for (genvar gi = 0; gi < N_STORE; gi++) begin : g_word
        localparam logic [WIDX_W-1:0] MY_IDX = WIDX_W'(BASE + gi);
        always_ff @(posedge clk) begin
            if (!rst_n)                       words[gi] <= '0;
            else if (wr_en && idx == MY_IDX)  words[gi] <= wdata;
        end
    end

    always_comb begin
        rdata = '0;
        hit   = 1'b0;
        for (int i = 0; i < N_STORE; i++) begin
            if (idx == WIDX_W'(BASE + i)) begin
                rdata = words[i];
                hit   = 1'b1;
            end
        end
    end
endmodule

// File: rtl/reload_timer.sv
module reload_timer
    import rt_pkg::*;
#(
    parameter int ADDR_W  = 8,
    parameter int CNT_W   = 16,
    parameter int PSC_W   = 16,
    parameter int N_STORE = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              upd_irq
);
    localparam int WIDX_W = ADDR_W - 2;
    localparam logic [WIDX_W-1:0] IX_CTRL   = WIDX_W'(WORD_CTRL);
    localparam logic [WIDX_W-1:0] IX_IEN    = WIDX_W'(WORD_IEN);
    localparam logic [WIDX_W-1:0] IX_STAT   = WIDX_W'(WORD_STAT);
    localparam logic [WIDX_W-1:0] IX_EVT    = WIDX_W'(WORD_EVT);
    localparam logic [WIDX_W-1:0] IX_COUNT  = WIDX_W'(WORD_COUNT);
    localparam logic [WIDX_W-1:0] IX_PDIV   = WIDX_W'(WORD_PDIV);
    localparam logic [WIDX_W-1:0] IX_RELOAD = WIDX_W'(WORD_RELOAD);

    logic [WIDX_W-1:0] widx;
    logic              aligned, wr_hit;
    logic              ctrl_wr, ien_wr, stat_wr, ug, cnt_wr, pdiv_wr, reload_wr;
    logic [31:1]       ctrl_hi_q;
    logic [31:0]       ien_q;
    logic [PSC_W-1:0]  pdiv_q;
    logic [CNT_W-1:0]  reload_q;
    logic              run, tick, stat;
    logic [CNT_W-1:0]  cnt;
    logic [31:0]       store_rdata;
    logic              store_hit;

    assign widx      = bus_addr[ADDR_W-1:2];
    assign aligned   = (bus_addr[1:0] == 2'b00);
    assign wr_hit    = bus_sel && bus_wr && aligned;
    assign ctrl_wr   = wr_hit && widx == IX_CTRL;
    assign ien_wr    = wr_hit && widx == IX_IEN;
    assign stat_wr   = wr_hit && widx == IX_STAT;
    assign ug        = wr_hit && widx == IX_EVT && bus_wdata[0];
    assign cnt_wr    = wr_hit && widx == IX_COUNT;
    assign pdiv_wr   = wr_hit && widx == IX_PDIV;
    assign reload_wr = wr_hit && widx == IX_RELOAD;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_hi_q <= '0;
            ien_q     <= '0;
            pdiv_q    <= '0;
            reload_q  <= '0;
        end else begin
            if (ctrl_wr)   ctrl_hi_q <= bus_wdata[31:1];
            if (ien_wr)    ien_q     <= bus_wdata;
            if (pdiv_wr)   pdiv_q    <= bus_wdata[PSC_W-1:0];
            if (reload_wr) reload_q  <= bus_wdata[CNT_W-1:0];
        end
    end

    rt_prescaler #(.PSC_W(PSC_W)) u_pscl (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .clr   (ug),
        .pdiv  (pdiv_q),
        .tick  (tick)
    );

    rt_count_fsm #(.CNT_W(CNT_W)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctrl_wr   (ctrl_wr),
        .ctrl_run  (bus_wdata[0]),
        .cnt_wr    (cnt_wr),
        .cnt_wdata (bus_wdata[CNT_W-1:0]),
        .ug        (ug),
        .tick      (tick),
        .reload    (reload_q),
        .upd_ien   (ien_q[0]),
        .stat_wr   (stat_wr),
        .stat_keep (bus_wdata[0]),
        .run       (run),
        .cnt       (cnt),
        .stat      (stat),
        .irq       (upd_irq)
    );

    rt_store #(.N_STORE(N_STORE), .WIDX_W(WIDX_W), .BASE(WORD_STORE0)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (wr_hit),
        .idx   (widx),
        .wdata (bus_wdata),
        .rdata (store_rdata),
        .hit   (store_hit)
    );

    always_comb begin
        bus_rdata = '0;
        if (aligned) begin
            case (widx)
                IX_CTRL:   bus_rdata = {ctrl_hi_q, run};
                IX_IEN:    bus_rdata = ien_q;
                IX_STAT:   bus_rdata = {31'b0, stat};
                IX_COUNT:  bus_rdata = 32'(cnt);
                IX_PDIV:   bus_rdata = 32'(pdiv_q);
                IX_RELOAD: bus_rdata = 32'(reload_q);
                default:   bus_rdata = store_hit ? store_rdata : 32'b0;
            endcase
        end
    end

    // R6: a divider write never moves the count unless a tick lands in that cycle
    assert_pdiv_keeps_count_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (pdiv_wr && !tick) |=> $stable(cnt));
    // R7: a count write is what the counter holds on the next cycle
    assert_count_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_wr |=> (32'(cnt) == 32'($past(bus_wdata[CNT_W-1:0]))));
endmodule

// File: tb/reload_timer_bench.sv
module reload_timer_bench;
    localparam int CW = 8;
    localparam int PW = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        upd_irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    reload_timer #(.ADDR_W(8), .CNT_W(CW), .PSC_W(PW), .N_STORE(4)) u_reload_timer (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .upd_irq(upd_irq)
    );

    typedef struct packed {
        logic        wr;
        logic [7:0]  a;
        logic [31:0] d;
        logic [31:0] e;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 31;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 8'h00, 32'h0, 32'h0, 8'd10},         // R10 reset reads
        '{1'b0, 8'h04, 32'h0, 32'h0, 8'd10},
        '{1'b0, 8'h08, 32'h0, 32'h0, 8'd10},
        '{1'b0, 8'h10, 32'h0, 32'h0, 8'd10},
        '{1'b0, 8'h14, 32'h0, 32'h0, 8'd10},
        '{1'b0, 8'h18, 32'h0, 32'h0, 8'd10},
        '{1'b0, 8'h20, 32'h0, 32'h0, 8'd10},
        '{1'b1, 8'h00, 32'hA5A5_0000, 32'h0, 8'd11},  // R11 control upper bits
        '{1'b0, 8'h00, 32'h0, 32'hA5A5_0000, 8'd11},
        '{1'b1, 8'h04, 32'h0000_FF00, 32'h0, 8'd11},
        '{1'b0, 8'h04, 32'h0, 32'h0000_FF00, 8'd11},
        '{1'b1, 8'h20, 32'hDEAD_BEEF, 32'h0, 8'd11},  // R11 storage words
        '{1'b1, 8'h2C, 32'h1234_5678, 32'h0, 8'd11},
        '{1'b0, 8'h20, 32'h0, 32'hDEAD_BEEF, 8'd11},
        '{1'b0, 8'h2C, 32'h0, 32'h1234_5678, 8'd11},
        '{1'b1, 8'h30, 32'hFFFF_FFFF, 32'h0, 8'd12},  // R12 undefined offsets
        '{1'b0, 8'h30, 32'h0, 32'h0, 8'd12},
        '{1'b1, 8'h1C, 32'h0000_0001, 32'h0, 8'd12},
        '{1'b0, 8'h1C, 32'h0, 32'h0, 8'd12},
        '{1'b0, 8'h21, 32'h0, 32'h0, 8'd12},
        '{1'b0, 8'h20, 32'h0, 32'hDEAD_BEEF, 8'd12},
        '{1'b1, 8'h10, 32'h0000_1234, 32'h0, 8'd7},   // R7 truncated count load
        '{1'b0, 8'h10, 32'h0, 32'h0000_0034, 8'd7},
        '{1'b1, 8'h14, 32'h0000_01FF, 32'h0, 8'd11},
        '{1'b0, 8'h14, 32'h0, 32'h0000_00FF, 8'd11},
        '{1'b0, 8'h10, 32'h0, 32'h0000_0034, 8'd6},   // R6 count kept
        '{1'b1, 8'h0C, 32'h0000_0000, 32'h0, 8'd5},   // R5 bit 0 clear: no effect
        '{1'b0, 8'h10, 32'h0, 32'h0000_0034, 8'd5},
        '{1'b0, 8'h0C, 32'h0, 32'h0, 8'd5},
        '{1'b1, 8'h0C, 32'h0000_0001, 32'h0, 8'd5},   // R5 forced restart
        '{1'b0, 8'h10, 32'h0, 32'h0, 8'd5}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic peek(input logic [7:0] a, output logic [31:0] v);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1;
        v = bus_rdata;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [31:0] v;
        logic [31:0] c0;
        int irq_hits;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R10 irq after reset", 32'(upd_irq), 32'h0);

        for (int i = 0; i < NV; i++) begin
            if (VECS[i].wr) begin
                wr(VECS[i].a, VECS[i].d);
            end else begin
                @(negedge clk);
                peek(VECS[i].a, v);
                checks++;
                if (v !== VECS[i].e) begin
                    errors++;
                    $display("FAIL R%0d vector %0d actual=0x%0h expected=0x%0h",
                             VECS[i].req, i, v, VECS[i].e);
                end
            end
        end
        wr(8'h00, 32'h0);
        wr(8'h04, 32'h0);

        // R1 / R3: divider 2, reload 4, interrupt enabled
        wr(8'h14, 32'd2);
        wr(8'h18, 32'd4);
        wr(8'h10, 32'd0);
        wr(8'h04, 32'd1);
        peek(8'h08, v);
        check("R3 flag clear before run", v, 32'h0);
        wr(8'h00, 32'd1);
        for (int k = 1; k <= 20; k++) begin
            @(negedge clk);
            peek(8'h10, v);
            check("R1 tick spacing count", v, 32'(((k / 3) % 5)));
            check("R3 pulse on wrap edge", 32'(upd_irq),
                  32'((k % 3 == 0) && ((k / 3) % 5 == 0)));
        end

        // R4: status AND semantics
        wr(8'h00, 32'd0);
        peek(8'h08, v);
        check("R3 flag set after wrap", v, 32'h1);
        wr(8'h08, 32'h1);
        peek(8'h08, v);
        check("R4 write one keeps flag", v, 32'h1);
        wr(8'h08, 32'hFFFF_FFFE);
        peek(8'h08, v);
        check("R4 write zero clears flag", v, 32'h0);

        // R2: halted counter holds
        peek(8'h10, c0);
        repeat (10) @(negedge clk);
        peek(8'h10, v);
        check("R2 halted count holds", v, c0);
        peek(8'h00, v);
        check("R2 control reads halted", v, 32'h0);

        // R5: forced restart with divider 3
        wr(8'h14, 32'd3);
        wr(8'h18, 32'd100);
        wr(8'h00, 32'd1);
        peek(8'h00, v);
        check("R2 control reads counting", v, 32'h1);
        repeat (10) @(negedge clk);
        wr(8'h0C, 32'd1);
        repeat (3) @(negedge clk);
        peek(8'h10, v);
        check("R5 count held at zero for divider period", v, 32'd0);
        @(negedge clk);
        peek(8'h10, v);
        check("R5 first tick after full period", v, 32'd1);

        // R6 / R7: halted load, divider write, then resume
        wr(8'h00, 32'd0);
        wr(8'h10, 32'd37);
        wr(8'h14, 32'd1);
        peek(8'h10, v);
        check("R6 divider write keeps count", v, 32'd37);
        wr(8'h00, 32'd1);
        repeat (3) @(negedge clk);
        peek(8'h10, v);
        check("R7 continues from loaded value", v, 32'd38);
        @(negedge clk);
        peek(8'h10, v);
        check("R7 second advance", v, 32'd39);

        // R9: interrupt disabled, wrap still happens
        wr(8'h00, 32'd0);
        wr(8'h08, 32'd0);
        wr(8'h04, 32'd0);
        wr(8'h14, 32'd0);
        wr(8'h18, 32'd3);
        wr(8'h10, 32'd0);
        wr(8'h00, 32'd1);
        irq_hits = 0;
        for (int k = 1; k <= 10; k++) begin
            @(negedge clk);
            peek(8'h10, v);
            check("R9 wrap without enable", v, 32'(k % 4));
            if (upd_irq) irq_hits++;
        end
        check("R9 no pulse when disabled", 32'(irq_hits), 32'd0);
        peek(8'h08, v);
        check("R9 no flag when disabled", v, 32'h0);

        // R8: reload zero, free-running counter
        wr(8'h00, 32'd0);
        wr(8'h18, 32'd0);
        wr(8'h10, 32'd0);
        wr(8'h04, 32'd1);
        wr(8'h00, 32'd1);
        irq_hits = 0;
        for (int k = 1; k <= 300; k++) begin
            @(negedge clk);
            if (upd_irq) irq_hits++;
        end
        peek(8'h10, v);
        check("R8 free-running wrap", v, 32'd44);
        check("R8 no pulse at reload zero", 32'(irq_hits), 32'd0);
        peek(8'h08, v);
        check("R8 no flag at reload zero", v, 32'h0);

        finish_run();
    end
endmodule